// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Unit

This block holds a small bank of byte-wide mailboxes shared by two independent buses: a host side and a local processor side. Each side accesses the bank as 32-bit words, so a single access covers four mailboxes through four byte lanes. Short commands or parameters pass between the two processors through these mailboxes without a streaming channel.

Each side can ask to be interrupted when the opposite side reads or writes a given mailbox. Each side owns two 16-bit enable words, one for read events and one for write events. A touched mailbox whose matching enable bit is set raises a sticky status bit. Read events from both sides merge into one 16-bit read status word, and write events into a separate write status word. Either side clears status bits by writing ones. Any pending status bit forms one shared request. Each side's interrupt output passes that request through the side's own global enable bit.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset all mailboxes, enable words, global bits and status words are zero, and both interrupt outputs are low.
- R2: Word address w (address bit 2 clear, w = address bits 1:0) maps mailbox 4w+j to byte lane j (data bits 8j+7 down to 8j). A write updates only the mailboxes whose byte enable bit is set, and leaves every other mailbox unchanged.
- R3: A read returns all four mailbox bytes of the addressed word on the read-data port one clock after the request, regardless of byte enables.
- R4: When both sides write the same mailbox in the same cycle, the host value is stored.
- R5: With address bit 2 set, address bits 1:0 pick a register. 0 is the side's own write-event enable (bits 15:0) with its global interrupt enable in bit 16. 1 is the side's own read-event enable (bits 15:0). 2 is the shared write status word and 3 is the shared read status word. Enable writes update only bytes whose byte enable is set (bit 16 under lane 2), and all four registers read back.
- R6: A write by one side to mailbox i with its lane enabled sets write status bit i when bit i of the other side's write-event enable is set. With that enable bit clear, the status bit stays clear.
- R7: A read by one side of mailbox i sets read status bit i when the lane's byte enable is set and bit i of the other side's read-event enable is set. Lanes whose byte enable is clear raise nothing.
- R8: One access touching several mailboxes sets one status bit for each touched mailbox whose enable is set.
- R9: Writing a 1 to a status bit (its byte lane enabled) from either side clears it. Writing 0, or writing with the lane disabled, leaves it unchanged.
- R10: If a doorbell event and a clear hit the same status bit in one cycle, the bit stays set.
- R11: Each interrupt output is high exactly when its side's global enable is set and any status bit is set. It follows the status words one clock after the triggering access.
- R12: Accesses to the register words raise no doorbell event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request, one cycle per access |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 3 | Host word address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| l_req | input | 1 | Local access request |
| l_wr | input | 1 | Local access is a write |
| l_addr | input | 3 | Local word address |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, registered |
| h_irq | output | 1 | Interrupt request to host |
| l_irq | output | 1 | Interrupt request to local side |

## Verification
On every cycle, the assertions check the following. A doorbell event lands in its status word on the next clock and is not lost to a same-cycle clear. A status bit neither rises without an event nor falls without a clear. An interrupt output is never high while both status words are empty, and no mailbox changes when no write targets it. The bench sweeps every word address and byte-enable pattern from both sides against an arithmetic model. Only those scenarios show the lane-to-mailbox mapping, read data contents, enable masking, the write collision priority, partial clears, and the gating by each side's global bit.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    REG_WEN   = 2'd0,
    REG_REN   = 2'd1,
    REG_WSTAT = 2'd2,
    REG_RSTAT = 2'd3
  } reg_sel_e;

  // Expand byte enables to a per-bit mask.
  function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = be[b / BYTE_W];
    return m;
  endfunction

  // Sticky status update: a set wins over a clear.
  function automatic logic [31:0] sticky_next(input logic [31:0] q,
                                              input logic [31:0] set,
                                              input logic [31:0] clr);
    return (q & ~clr) | set;
  endfunction
endpackage

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 16,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          be,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NUM_MBX*BYTE_W-1:0] mbx_flat,
  input  logic [NUM_MBX-1:0]        wstat,
  input  logic [NUM_MBX-1:0]        rstat,
  output logic [NUM_MBX-1:0]        wr_hit,
  output logic [NUM_MBX-1:0]        rd_hit,
  output logic [NUM_MBX-1:0]        clr_w,
  output logic [NUM_MBX-1:0]        clr_r,
  output logic [NUM_MBX-1:0]        own_wen,
  output logic [NUM_MBX-1:0]        own_ren,
  output logic                      own_glb,
  output logic [DATA_W-1:0]         rdata
);
  localparam int WIDX_W    = ADDR_W - 1;
  localparam int NUM_WORDS = NUM_MBX / LANES;

  function automatic logic [NUM_MBX-1:0] hit_mask(input logic [WIDX_W-1:0] w,
                                                  input logic [LANES-1:0] b);
    logic [NUM_MBX-1:0] m;
    for (int i = 0; i < NUM_MBX; i++) m[i] = (i / LANES == int'(w)) && b[i % LANES];
    return m;
  endfunction

  logic              is_reg;
  logic [WIDX_W-1:0] widx;
  reg_sel_e          sel;
  logic              in_range;
  logic [DATA_W-1:0] lanes;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] rd_mbx;
  logic [DATA_W-1:0] rd_next;
  logic              reg_wr;

  assign is_reg   = addr[ADDR_W-1];
  assign widx     = addr[WIDX_W-1:0];
  assign sel      = reg_sel_e'(addr[1:0]);
  assign in_range = int'(widx) < NUM_WORDS;
  assign lanes    = lane_bits(be);
  assign wmask    = wdata & lanes;
  assign reg_wr   = req && wr && is_reg;

  assign wr_hit = (req && wr && !is_reg && in_range)  ? hit_mask(widx, be) : '0;
  assign rd_hit = (req && !wr && !is_reg && in_range) ? hit_mask(widx, be) : '0;
  assign clr_w  = (reg_wr && sel == REG_WSTAT) ? wmask[NUM_MBX-1:0] : '0;
  assign clr_r  = (reg_wr && sel == REG_RSTAT) ? wmask[NUM_MBX-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_wen <= '0;
      own_ren <= '0;
      own_glb <= 1'b0;
    end else if (reg_wr) begin
      if (sel == REG_WEN) begin
        own_wen <= (own_wen & ~lanes[NUM_MBX-1:0]) | wmask[NUM_MBX-1:0];
        if (lanes[NUM_MBX]) own_glb <= wdata[NUM_MBX];
      end else if (sel == REG_REN) begin
        own_ren <= (own_ren & ~lanes[NUM_MBX-1:0]) | wmask[NUM_MBX-1:0];
      end
    end
  end

  always_comb begin
    rd_mbx = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (int'(widx) == w) rd_mbx = mbx_flat[w*DATA_W +: DATA_W];
  end

  always_comb begin
    rd_next = '0;
    if (!is_reg) begin
      rd_next = rd_mbx;
    end else begin
      case (sel)
        REG_WEN:   rd_next[NUM_MBX:0]   = {own_glb, own_wen};
        REG_REN:   rd_next[NUM_MBX-1:0] = own_ren;
        REG_WSTAT: rd_next[NUM_MBX-1:0] = wstat;
        default:   rd_next[NUM_MBX-1:0] = rstat;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (req && !wr) rdata <= rd_next;
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_MBX-1:0]        h_wmask,
  input  logic [NUM_MBX-1:0]        l_wmask,
  input  logic [DATA_W-1:0]         h_wdata,
  input  logic [DATA_W-1:0]         l_wdata,
  output logic [NUM_MBX*BYTE_W-1:0] mbx_flat
);
  for (genvar i = 0; i < NUM_MBX; i++) begin : g_box
    localparam int LANE = i % LANES;
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          byte_q <= '0;
      else if (h_wmask[i]) byte_q <= h_wdata[LANE*BYTE_W +: BYTE_W];
      else if (l_wmask[i]) byte_q <= l_wdata[LANE*BYTE_W +: BYTE_W];
    end
    assign mbx_flat[i*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MBX-1:0] set_w,
  input  logic [NUM_MBX-1:0] set_r,
  input  logic [NUM_MBX-1:0] clr_w,
  input  logic [NUM_MBX-1:0] clr_r,
  output logic [NUM_MBX-1:0] wstat,
  output logic [NUM_MBX-1:0] rstat
);
  logic [31:0] w_nx, r_nx;
  assign w_nx = sticky_next(32'(wstat), 32'(set_w), 32'(clr_w));
  assign r_nx = sticky_next(32'(rstat), 32'(set_r), 32'(clr_r));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wstat <= '0;
      rstat <= '0;
    end else begin
      wstat <= w_nx[NUM_MBX-1:0];
      rstat <= r_nx[NUM_MBX-1:0];
    end
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 16,
  parameter int ADDR_W  = $clog2(NUM_MBX / 4) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [3:0]        h_be,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  input  logic              l_req,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [3:0]        l_be,
  input  logic [31:0]       l_wdata,
  output logic [31:0]       l_rdata,
  output logic              h_irq,
  output logic              l_irq
);
  logic [NUM_MBX*BYTE_W-1:0] mbx_flat;
  logic [NUM_MBX-1:0] wstat, rstat;
  logic [NUM_MBX-1:0] h_wr_hit, h_rd_hit, h_clr_w, h_clr_r, h_wen, h_ren;
  logic [NUM_MBX-1:0] l_wr_hit, l_rd_hit, l_clr_w, l_clr_r, l_wen, l_ren;
  logic h_glb, l_glb;

  // Named internal events
  logic [NUM_MBX-1:0] ev_wr_set, ev_rd_set, clr_wr_all, clr_rd_all;
  logic irq_any;

  mbx_port #(.NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W)) u_host (
    .clk, .rst_n, .req(h_req), .wr(h_wr), .addr(h_addr), .be(h_be), .wdata(h_wdata),
    .mbx_flat, .wstat, .rstat,
    .wr_hit(h_wr_hit), .rd_hit(h_rd_hit), .clr_w(h_clr_w), .clr_r(h_clr_r),
    .own_wen(h_wen), .own_ren(h_ren), .own_glb(h_glb), .rdata(h_rdata)
  );

  mbx_port #(.NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W)) u_local (
    .clk, .rst_n, .req(l_req), .wr(l_wr), .addr(l_addr), .be(l_be), .wdata(l_wdata),
    .mbx_flat, .wstat, .rstat,
    .wr_hit(l_wr_hit), .rd_hit(l_rd_hit), .clr_w(l_clr_w), .clr_r(l_clr_r),
    .own_wen(l_wen), .own_ren(l_ren), .own_glb(l_glb), .rdata(l_rdata)
  );

  mbx_store #(.NUM_MBX(NUM_MBX)) u_store (
    .clk, .rst_n, .h_wmask(h_wr_hit), .l_wmask(l_wr_hit),
    .h_wdata, .l_wdata, .mbx_flat
  );

  // An event interrupts the opposite side, so it is gated by that side's enables.
  assign ev_wr_set  = (h_wr_hit & l_wen) | (l_wr_hit & h_wen);
  assign ev_rd_set  = (h_rd_hit & l_ren) | (l_rd_hit & h_ren);
  assign clr_wr_all = h_clr_w | l_clr_w;
  assign clr_rd_all = h_clr_r | l_clr_r;

  mbx_status #(.NUM_MBX(NUM_MBX)) u_status (
    .clk, .rst_n, .set_w(ev_wr_set), .set_r(ev_rd_set),
    .clr_w(clr_wr_all), .clr_r(clr_rd_all), .wstat, .rstat
  );

  assign irq_any = (|wstat) | (|rstat);
  assign h_irq   = irq_any & h_glb;
  assign l_irq   = irq_any & l_glb;
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int NUM_MBX = 16,
  parameter int ADDR_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                h_req,
  input logic [ADDR_W-1:0]   h_addr,
  input logic                h_irq,
  input logic                l_irq,
  input logic [NUM_MBX-1:0]  wstat,
  input logic [NUM_MBX-1:0]  rstat,
  input logic [NUM_MBX-1:0]  ev_wr_set,
  input logic [NUM_MBX-1:0]  ev_rd_set,
  input logic [NUM_MBX-1:0]  clr_wr_all,
  input logic [NUM_MBX-1:0]  clr_rd_all,
  input logic [NUM_MBX-1:0]  h_wr_hit,
  input logic [NUM_MBX-1:0]  l_wr_hit,
  input logic [NUM_MBX-1:0]  h_rd_hit,
  input logic [NUM_MBX*8-1:0] mbx_flat
);
  // R6 / R10: a write event lands even against a same-cycle clear
  p_wr_event_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_set != '0) |=> ((wstat & $past(ev_wr_set)) == $past(ev_wr_set)));

  // R7: read event lands
  p_rd_event_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_set != '0) |=> ((rstat & $past(ev_rd_set)) == $past(ev_rd_set)));

  // R9: status bits fall only when cleared
  p_wr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wstat & ($past(wstat) & ~$past(clr_wr_all))) == ($past(wstat) & ~$past(clr_wr_all))));
  p_rd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rstat & ($past(rstat) & ~$past(clr_rd_all))) == ($past(rstat) & ~$past(clr_rd_all))));

  // R6: no status bit rises without an event
  p_wr_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wstat & ~$past(wstat) & ~$past(ev_wr_set)) == '0));
  p_rd_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rstat & ~$past(rstat) & ~$past(ev_rd_set)) == '0));

  // R11: an interrupt needs a pending status bit
  p_h_irq_needs_stat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> ((wstat | rstat) != '0));
  p_l_irq_needs_stat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    l_irq |-> ((wstat | rstat) != '0));

  // R2: mailboxes hold when no write targets them
  p_mbx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_wr_hit | l_wr_hit) == '0) |=> $stable(mbx_flat));

  // R12: register-word accesses touch no mailbox
  p_reg_no_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_addr[ADDR_W-1]) |-> ((h_wr_hit | h_rd_hit) == '0));
endmodule

bind mbx_doorbell mbx_doorbell_chk #(.NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_addr(h_addr),
  .h_irq(h_irq), .l_irq(l_irq), .wstat(wstat), .rstat(rstat),
  .ev_wr_set(ev_wr_set), .ev_rd_set(ev_rd_set),
  .clr_wr_all(clr_wr_all), .clr_rd_all(clr_rd_all),
  .h_wr_hit(h_wr_hit), .l_wr_hit(l_wr_hit), .h_rd_hit(h_rd_hit),
  .mbx_flat(mbx_flat)
);

// File: tb/mbx_doorbell_tb.sv
module mbx_doorbell_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_req = 0, h_wr = 0, l_req = 0, l_wr = 0;
  logic [2:0] h_addr = '0, l_addr = '0;
  logic [3:0] h_be = '0, l_be = '0;
  logic [31:0] h_wdata = '0, l_wdata = '0;
  logic [31:0] h_rdata, l_rdata;
  logic h_irq, l_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mbx_doorbell u_dut (
    .clk, .rst_n, .h_req, .h_wr, .h_addr, .h_be, .h_wdata, .h_rdata,
    .l_req, .l_wr, .l_addr, .l_be, .l_wdata, .l_rdata, .h_irq, .l_irq
  );

  // Bench model
  logic [7:0]  m_mbx [16];
  logic [15:0] m_hwen, m_hren, m_lwen, m_lren, m_wst, m_rst;
  logic        m_hg, m_lg;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] lanes16(input logic [3:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // One access from one side; updates the model and returns read data.
  task automatic acc(input bit side, input bit wr, input logic [2:0] a,
                     input logic [3:0] be, input logic [31:0] d,
                     output logic [31:0] exp_rd, output logic [31:0] got);
    exp_rd = '0;
    if (!a[2]) begin
      for (int j = 0; j < 4; j++) exp_rd[8*j +: 8] = m_mbx[4*a[1:0] + j];
      for (int j = 0; j < 4; j++) begin
        int k = 4*a[1:0] + j;
        if (be[j]) begin
          if (wr) begin
            m_mbx[k] = d[8*j +: 8];
            if (side ? m_hwen[k] : m_lwen[k]) m_wst[k] = 1'b1;
          end else begin
            if (side ? m_hren[k] : m_lren[k]) m_rst[k] = 1'b1;
          end
        end
      end
    end else begin
      case (a[1:0])
        2'd0: begin
          exp_rd = side ? {15'd0, m_lg, m_lwen} : {15'd0, m_hg, m_hwen};
          if (wr) begin
            if (side) begin
              m_lwen = (m_lwen & ~lanes16(be)) | (d[15:0] & lanes16(be));
              if (be[2]) m_lg = d[16];
            end else begin
              m_hwen = (m_hwen & ~lanes16(be)) | (d[15:0] & lanes16(be));
              if (be[2]) m_hg = d[16];
            end
          end
        end
        2'd1: begin
          exp_rd = side ? {16'd0, m_lren} : {16'd0, m_hren};
          if (wr) begin
            if (side) m_lren = (m_lren & ~lanes16(be)) | (d[15:0] & lanes16(be));
            else      m_hren = (m_hren & ~lanes16(be)) | (d[15:0] & lanes16(be));
          end
        end
        2'd2: begin
          exp_rd = {16'd0, m_wst};
          if (wr) m_wst = m_wst & ~(d[15:0] & lanes16(be));
        end
        default: begin
          exp_rd = {16'd0, m_rst};
          if (wr) m_rst = m_rst & ~(d[15:0] & lanes16(be));
        end
      endcase
    end
    @(negedge clk);
    if (side) begin
      l_req = 1; l_wr = wr; l_addr = a; l_be = be; l_wdata = d;
    end else begin
      h_req = 1; h_wr = wr; h_addr = a; h_be = be; h_wdata = d;
    end
    @(negedge clk);
    got = side ? l_rdata : h_rdata;
    h_req = 0; l_req = 0; h_wr = 0; l_wr = 0;
  endtask

  task automatic check_irq(input string tag);
    chk({tag, " h_irq"}, 32'(h_irq), 32'(m_hg && ((m_wst | m_rst) != 0)));
    chk({tag, " l_irq"}, 32'(l_irq), 32'(m_lg && ((m_wst | m_rst) != 0)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] e, g;
    for (int i = 0; i < 16; i++) m_mbx[i] = '0;
    m_hwen = '0; m_hren = '0; m_lwen = '0; m_lren = '0;
    m_wst = '0; m_rst = '0; m_hg = 0; m_lg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_irq("R1");
    for (int a = 0; a < 8; a++) begin
      acc(0, 0, 3'(a), 4'hF, 0, e, g); chk("R1 host reset read", g, 32'd0);
      acc(1, 0, 3'(a), 4'hF, 0, e, g); chk("R1 local reset read", g, 32'd0);
    end

    // R5: program enables, read back; partial lane write
    acc(0, 1, 3'd4, 4'hF, 32'h0001_A5C3, e, g);
    acc(0, 1, 3'd5, 4'hF, 32'h0000_3C5A, e, g);
    acc(1, 1, 3'd4, 4'hF, 32'h0001_5AA5, e, g);
    acc(1, 1, 3'd5, 4'hF, 32'h0000_C33C, e, g);
    acc(1, 1, 3'd5, 4'h2, 32'h0000_FFFF, e, g);
    acc(0, 0, 3'd4, 4'hF, 0, e, g); chk("R5 host wen", g, e);
    acc(0, 0, 3'd5, 4'hF, 0, e, g); chk("R5 host ren", g, e);
    acc(1, 0, 3'd4, 4'hF, 0, e, g); chk("R5 local wen", g, e);
    acc(1, 0, 3'd5, 4'hF, 0, e, g); chk("R5 local ren lane", g, 32'h0000_FF3C);
    // R12: register accesses raise nothing
    acc(0, 0, 3'd6, 4'hF, 0, e, g); chk("R12 wstat after reg access", g, 32'd0);
    acc(0, 0, 3'd7, 4'hF, 0, e, g); chk("R12 rstat after reg access", g, 32'd0);

    // R2 R3 R6 R7 R8 R11: sweep both sides, all words, all byte enables
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 4; a++) begin
        for (int be = 1; be < 16; be++) begin
          logic [31:0] d;
          d = {4{8'(16*a + be) ^ (s != 0 ? 8'h5A : 8'h00)}} ^ 32'h0102_0304;
          acc(s[0], 1, 3'(a), 4'(be), d, e, g);
          check_irq("R11 after write");
          acc(s[0], 0, 3'd6, 4'hF, 0, e, g); chk("R6 R8 wstat", g, e);
          acc(!s[0], 0, 3'(a), 4'(be), 0, e, g); chk("R2 R3 read word", g, e);
          acc(s[0], 0, 3'd7, 4'hF, 0, e, g); chk("R7 rstat", g, e);
          check_irq("R11 after read");
          acc(s[0], 1, 3'd6, 4'h3, 32'hFFFF, e, g);
          acc(!s[0], 1, 3'd7, 4'h3, 32'hFFFF, e, g);
          acc(s[0], 0, 3'd6, 4'hF, 0, e, g); chk("R9 wstat cleared", g, 32'd0);
          check_irq("R9 irq after clear");
        end
      end
    end

    // R9: partial clear, zeros and disabled lane leave bits
    acc(1, 1, 3'd0, 4'hF, 32'hDEAD_BEEF, e, g);
    acc(1, 1, 3'd1, 4'hF, 32'h1234_5678, e, g);
    acc(0, 1, 3'd6, 4'h1, 32'h0000_0101, e, g);
    acc(0, 0, 3'd6, 4'hF, 0, e, g); chk("R9 partial clear", g, e);
    acc(1, 1, 3'd6, 4'hF, 32'hFFFF_FFFF, e, g);
    acc(0, 0, 3'd6, 4'hF, 0, e, g); chk("R9 full clear", g, 32'd0);

    // R11: local global off gates only local interrupt
    acc(1, 1, 3'd4, 4'h4, 32'h0000_0000, e, g);
    acc(0, 1, 3'd0, 4'h1, 32'h0000_0077, e, g);
    chk("R11 host irq on", 32'(h_irq), 32'd1);
    chk("R11 local irq gated", 32'(l_irq), 32'd0);

    // R4: simultaneous writes to mailbox 0, host wins
    @(negedge clk);
    h_req = 1; h_wr = 1; h_addr = 3'd0; h_be = 4'h1; h_wdata = 32'h0000_0011;
    l_req = 1; l_wr = 1; l_addr = 3'd0; l_be = 4'h1; l_wdata = 32'h0000_0022;
    @(negedge clk);
    h_req = 0; l_req = 0; h_wr = 0; l_wr = 0;
    m_mbx[0] = 8'h11;
    if (m_lwen[0] || m_hwen[0]) m_wst[0] = 1'b1;
    acc(1, 0, 3'd0, 4'h0, 0, e, g); chk("R4 host wins", g, e);

    // R10: clear and new event on bit 0 in the same cycle
    @(negedge clk);
    h_req = 1; h_wr = 1; h_addr = 3'd6; h_be = 4'h3; h_wdata = 32'h0000_FFFF;
    l_req = 1; l_wr = 1; l_addr = 3'd0; l_be = 4'h1; l_wdata = 32'h0000_0033;
    @(negedge clk);
    h_req = 0; l_req = 0; h_wr = 0; l_wr = 0;
    m_mbx[0] = 8'h33;
    m_wst = {15'd0, m_hwen[0]};
    acc(0, 0, 3'd6, 4'hF, 0, e, g); chk("R10 set wins", g, 32'h0000_0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule